// File: doc/BRIEF.md
# Move-Triggered Execution Datapath

This block is the execution half of a small processor whose program consists only of data moves. Every instruction word carries four move slots. A slot copies a value from a source port to a destination port, and it may be guarded by a one-bit condition register. No operation codes exist. An arithmetic or compare operation starts when a move lands on one of a unit's trigger ports. The address of that trigger port selects which operation runs.

The datapath contains the following parts:
- A sixteen-entry integer register file.
- An integer ALU with a plain operand port, six trigger ports and a result port.
- A compare unit that uses the same operand and trigger protocol.
- Three guard registers.
- A long-immediate register, loaded from a side field that travels with each instruction word.

Instruction words arrive with a valid strobe, one per clock. Register contents can be read combinationally through an inspection port, and the guard registers are always visible.

Each slot is 16 bits wide. Slot i occupies word bits [16i+15:16i]. Inside a slot, bit 15 is reserved and ignored. Bits [14:13] are the guard code, bit 12 is the immediate flag, bits [11:6] are the source and bits [5:0] are the destination.

Port map:
- Sources:
  - 0x00–0x0F: registers.
  - 0x10: ALU result.
  - 0x11: compare result.
  - 0x12: long-immediate register.
  - Any other code reads as zero.
- Destinations:
  - 0x00–0x0F: registers.
  - 0x10: ALU operand.
  - 0x18–0x1D: ALU triggers, in the order add, sub, and, or, xor, shift-left.
  - 0x20: compare operand.
  - 0x21: compare trigger, equal.
  - 0x22: compare trigger, signed less-than.
  - 0x29, 0x2A, 0x2B: guard registers g1, g2, g3.
  - Any other code is dropped.

Top module: `tta_move_core`

## Requirements
- R1: A slot takes effect only when instr_valid is high and its guard is true. Guard code 0 is always true, and codes 1, 2 and 3 select g1, g2 and g3. A move that does not take effect changes no state. When instr_valid is low, no state changes.
- R2: When the immediate flag (slot bit 12) is set, the 6-bit source field itself is the transported value, sign-extended to 32 bits.
- R3: When instr_valid and instr_limm_en are both high, instr_limm is loaded into the long-immediate register. Source 0x12 reads that register. A move in the same word still reads the previous value.
- R4: A move to 0x10 stores the ALU operand. A move to trigger 0x18+k computes (stored operand op transported value), where k=0 is add, 1 is sub, 2 is and, 3 is or, 4 is xor and 5 is shift-left by the low 5 bits of the transported value. The result is readable at source 0x10 from the next word on, and it holds until the next trigger.
- R5: A move to 0x20 stores the compare operand. Trigger 0x21 gives 1 if the stored operand equals the transported value, and trigger 0x22 gives 1 if the stored operand is signed-less-than the transported value; otherwise the result is 0. The result is readable at source 0x11 from the next word on.
- R6: A move to 0x29, 0x2A or 0x2B writes bit 0 of the transported value into g1, g2 or g3 respectively.
- R7: All sources, guard registers and stored operands in one word are sampled before any destination of that word is written.
- R8: When several effective slots of one word write the same destination, the slot with the highest index wins.
- R9: Reset, synchronous and active low, clears all registers, both stored operands, both results, the guards and the long-immediate register.
- R10: An unmapped source reads as zero. A move to an unmapped destination has no effect.
- R11: insp_data shows register insp_sel combinationally, and guard_state[j] shows guard g(j+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word valid this cycle |
| instr_word | input | 64 | Four 16-bit move slots |
| instr_limm_en | input | 1 | Load long-immediate register with this word |
| instr_limm | input | 32 | Long-immediate value |
| insp_sel | input | 4 | Register index for inspection |
| insp_data | output | 32 | Contents of register insp_sel |
| guard_state | output | 3 | Current g3..g1 |

## Verification
The assertions assume that instr_valid, instr_word and instr_limm_en are known (never X) at every clock edge after reset. They also assume the bench holds reset low from time zero. Under those assumptions, they relate guard codes in the incoming word to each slot's effect, and they require results and guards to hold while no word is valid. The random stimulus drives known values only. It picks destinations mostly from the mapped port set and sometimes from unmapped codes, and it weights guard code 0 so that most moves take effect. Directed words cover sign extension, reads before writes in one word, and higher-slot priority.

// File: rtl/tta_pkg.sv
`timescale 1ns/1ps
// Package: shared slot format, port map and unit kinds for the move datapath.
package tta_pkg;
    localparam int SLOT_W   = 16;
    localparam int PORT_W   = 6;
    localparam int GUARD_W  = 2;

    // Source port addresses beyond the register window.
    localparam logic [PORT_W-1:0] SRC_ALU_R  = 6'h10;
    localparam logic [PORT_W-1:0] SRC_CMP_R  = 6'h11;
    localparam logic [PORT_W-1:0] SRC_LIMM   = 6'h12;

    // Destination port addresses beyond the register window.
    localparam logic [PORT_W-1:0] DST_ALU_O1   = 6'h10;
    localparam logic [PORT_W-1:0] DST_ALU_TRIG = 6'h18;
    localparam int                ALU_NUM_OPS  = 6;
    localparam logic [PORT_W-1:0] DST_CMP_O1   = 6'h20;
    localparam logic [PORT_W-1:0] DST_CMP_TRIG = 6'h21;
    localparam int                CMP_NUM_OPS  = 2;
    localparam logic [PORT_W-1:0] DST_GUARD    = 6'h28;  // +1..+3 select g1..g3

    typedef struct packed {
        logic               rsvd;
        logic [GUARD_W-1:0] guard;
        logic               imm;
        logic [PORT_W-1:0]  src;
        logic [PORT_W-1:0]  dst;
    } move_slot_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_SHL = 3'd5
    } alu_op_e;

    typedef enum logic {
        FU_ALU = 1'b0,
        FU_CMP = 1'b1
    } fu_kind_e;
endpackage

// File: rtl/tta_slot.sv
`timescale 1ns/1ps
// Module: tta_slot
// Decodes one move slot: evaluates its guard, selects the source value
// (register, unit result, long immediate or short immediate) and presents
// an enable, destination and data for the destination side.
// Assumes all inputs are start-of-cycle state (reads before writes).
module tta_slot
    import tta_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RF_DEPTH   = 16,
    parameter int NUM_GUARDS = 3,
    localparam int RF_AW     = $clog2(RF_DEPTH)
) (
    input  logic                  instr_valid,
    input  logic [SLOT_W-1:0]     slot_bits,
    input  logic [NUM_GUARDS:0]   guard_vec,
    input  logic [DATA_W-1:0]     rf_rdata,
    input  logic [DATA_W-1:0]     alu_r,
    input  logic [DATA_W-1:0]     cmp_r,
    input  logic [DATA_W-1:0]     limm_q,
    output logic [RF_AW-1:0]      rf_raddr,
    output logic                  xfer_en,
    output logic [PORT_W-1:0]     xfer_dst,
    output logic [DATA_W-1:0]     xfer_data
);
    move_slot_t slot;
    logic       guard_ok;

    assign slot     = move_slot_t'(slot_bits);
    assign rf_raddr = slot.src[RF_AW-1:0];
    assign xfer_dst = slot.dst;

    // Guard evaluation: code 0 is hard-wired true through guard_vec[0].
    always_comb begin
        guard_ok = 1'b0;
        if (int'(slot.guard) <= NUM_GUARDS) guard_ok = guard_vec[slot.guard];
        xfer_en = instr_valid && guard_ok;
    end

    // Source selection onto the transport.
    always_comb begin
        if (slot.imm) begin
            xfer_data = {{(DATA_W-PORT_W){slot.src[PORT_W-1]}}, slot.src};
        end else if (int'(slot.src) < RF_DEPTH) begin
            xfer_data = rf_rdata;
        end else begin
            unique case (slot.src)
                SRC_ALU_R: xfer_data = alu_r;
                SRC_CMP_R: xfer_data = cmp_r;
                SRC_LIMM:  xfer_data = limm_q;
                default:   xfer_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/tta_regfile.sv
`timescale 1ns/1ps
// Module: tta_regfile
// Multi-port register file, one read and one write port per move slot,
// plus one inspection read port. Write ports are applied in index order,
// so the highest-indexed port wins on an address clash.
module tta_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int NPORTS = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORTS-1:0][AW-1:0]     rd_addr,
    output logic [NPORTS-1:0][DATA_W-1:0] rd_data,
    input  logic [NPORTS-1:0]             wr_en,
    input  logic [NPORTS-1:0][AW-1:0]     wr_addr,
    input  logic [NPORTS-1:0][DATA_W-1:0] wr_data,
    input  logic [AW-1:0]                 insp_addr,
    output logic [DATA_W-1:0]             insp_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: reset clear, then ordered port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
            end
        end
    end

    // Combinational read ports.
    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

    assign insp_data = mem[insp_addr];
endmodule

// File: rtl/tta_fu.sv
`timescale 1ns/1ps
// Module: tta_fu
// Function unit driven by moves: a plain operand port stores a value, and a
// write to one of NUM_OPS trigger ports computes (stored operand, moved
// value) with the operation chosen by the trigger address. The result
// register updates at the clock edge, giving one cycle of latency.
// KIND selects ALU or compare arithmetic. Highest slot wins on clashes.
module tta_fu
    import tta_pkg::*;
#(
    parameter fu_kind_e          KIND      = FU_ALU,
    parameter int                DATA_W    = 32,
    parameter int                NUM_SLOTS = 4,
    parameter logic [PORT_W-1:0] O1_ADDR   = DST_ALU_O1,
    parameter logic [PORT_W-1:0] TRIG_BASE = DST_ALU_TRIG,
    parameter int                NUM_OPS   = ALU_NUM_OPS,
    localparam int               SH_W      = $clog2(DATA_W)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SLOTS-1:0]             xfer_en,
    input  logic [NUM_SLOTS-1:0][PORT_W-1:0] xfer_dst,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] xfer_data,
    output logic [DATA_W-1:0]                result
);
    logic [DATA_W-1:0] o1_q, r_q;
    logic              o1_hit, trig_hit;
    logic [DATA_W-1:0] o1_next, trig_val, calc;
    logic [2:0]        trig_op;

    // Port decode: later slots override earlier ones.
    always_comb begin
        o1_hit   = 1'b0;
        o1_next  = '0;
        trig_hit = 1'b0;
        trig_val = '0;
        trig_op  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (xfer_en[s] && xfer_dst[s] == O1_ADDR) begin
                o1_hit  = 1'b1;
                o1_next = xfer_data[s];
            end
            if (xfer_en[s] && xfer_dst[s] >= TRIG_BASE &&
                int'(xfer_dst[s]) < int'(TRIG_BASE) + NUM_OPS) begin
                trig_hit = 1'b1;
                trig_val = xfer_data[s];
                trig_op  = 3'(xfer_dst[s] - TRIG_BASE);
            end
        end
    end

    // Operation datapath, chosen by unit kind.
    if (KIND == FU_ALU) begin : g_alu
        always_comb begin
            unique case (alu_op_e'(trig_op))
                ALU_ADD: calc = o1_q + trig_val;
                ALU_SUB: calc = o1_q - trig_val;
                ALU_AND: calc = o1_q & trig_val;
                ALU_OR:  calc = o1_q | trig_val;
                ALU_XOR: calc = o1_q ^ trig_val;
                ALU_SHL: calc = o1_q << trig_val[SH_W-1:0];
                default: calc = o1_q;
            endcase
        end
    end else begin : g_cmp
        always_comb begin
            calc = '0;
            if (trig_op == 3'd0) calc[0] = (o1_q == trig_val);
            else                 calc[0] = ($signed(o1_q) < $signed(trig_val));
        end
    end

    // Operand and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o1_q <= '0;
            r_q  <= '0;
        end else begin
            if (o1_hit)   o1_q <= o1_next;
            if (trig_hit) r_q  <= calc;
        end
    end

    assign result = r_q;
endmodule

// File: rtl/tta_move_core.sv
`timescale 1ns/1ps
// Module: tta_move_core
// Move-triggered execution datapath. Each valid instruction word carries
// NUM_SLOTS move slots executed in one cycle: all sources are read first,
// then all destinations are written, highest slot winning on clashes.
// Holds a register file, an ALU unit, a compare unit, guard registers and
// a long-immediate register loaded from the side field of the word.
module tta_move_core
    import tta_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int DATA_W     = 32,
    parameter int RF_DEPTH   = 16,
    parameter int NUM_GUARDS = 3,
    localparam int RF_AW     = $clog2(RF_DEPTH),
    localparam int WORD_W    = NUM_SLOTS * SLOT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [WORD_W-1:0]     instr_word,
    input  logic                  instr_limm_en,
    input  logic [DATA_W-1:0]     instr_limm,
    input  logic [RF_AW-1:0]      insp_sel,
    output logic [DATA_W-1:0]     insp_data,
    output logic [NUM_GUARDS-1:0] guard_state
);
    logic [NUM_SLOTS-1:0]              xfer_en;
    logic [NUM_SLOTS-1:0][PORT_W-1:0]  xfer_dst;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  xfer_data;
    logic [NUM_SLOTS-1:0][RF_AW-1:0]   rf_raddr;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  rf_rdata;
    logic [NUM_SLOTS-1:0]              rf_wen;
    logic [NUM_SLOTS-1:0][RF_AW-1:0]   rf_waddr;
    logic [DATA_W-1:0]                 alu_r, cmp_r, limm_q;
    logic [NUM_GUARDS-1:0]             guard_q;
    logic [NUM_GUARDS:0]               guard_vec;

    assign guard_vec = {guard_q, 1'b1};

    // One decoder per move slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        tta_slot #(
            .DATA_W(DATA_W), .RF_DEPTH(RF_DEPTH), .NUM_GUARDS(NUM_GUARDS)
        ) u_slot (
            .instr_valid (instr_valid),
            .slot_bits   (instr_word[s*SLOT_W +: SLOT_W]),
            .guard_vec   (guard_vec),
            .rf_rdata    (rf_rdata[s]),
            .alu_r       (alu_r),
            .cmp_r       (cmp_r),
            .limm_q      (limm_q),
            .rf_raddr    (rf_raddr[s]),
            .xfer_en     (xfer_en[s]),
            .xfer_dst    (xfer_dst[s]),
            .xfer_data   (xfer_data[s])
        );
        assign rf_wen[s]   = xfer_en[s] && (int'(xfer_dst[s]) < RF_DEPTH);
        assign rf_waddr[s] = xfer_dst[s][RF_AW-1:0];
    end

    tta_regfile #(
        .DATA_W(DATA_W), .DEPTH(RF_DEPTH), .NPORTS(NUM_SLOTS)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rf_raddr),
        .rd_data   (rf_rdata),
        .wr_en     (rf_wen),
        .wr_addr   (rf_waddr),
        .wr_data   (xfer_data),
        .insp_addr (insp_sel),
        .insp_data (insp_data)
    );

    tta_fu #(
        .KIND(FU_ALU), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS),
        .O1_ADDR(DST_ALU_O1), .TRIG_BASE(DST_ALU_TRIG), .NUM_OPS(ALU_NUM_OPS)
    ) u_alu (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .xfer_dst(xfer_dst),
        .xfer_data(xfer_data), .result(alu_r)
    );

    tta_fu #(
        .KIND(FU_CMP), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS),
        .O1_ADDR(DST_CMP_O1), .TRIG_BASE(DST_CMP_TRIG), .NUM_OPS(CMP_NUM_OPS)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .xfer_dst(xfer_dst),
        .xfer_data(xfer_data), .result(cmp_r)
    );

    // Guard registers: bit 0 of the moved value, highest slot wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                for (int g = 1; g <= NUM_GUARDS; g++) begin
                    if (xfer_en[s] && int'(xfer_dst[s]) == int'(DST_GUARD) + g)
                        guard_q[g-1] <= xfer_data[s][0];
                end
            end
        end
    end

    // Long-immediate register loaded from the word's side field.
    always_ff @(posedge clk) begin
        if (!rst_n)                           limm_q <= '0;
        else if (instr_valid && instr_limm_en) limm_q <= instr_limm;
    end

    assign guard_state = guard_q;
endmodule

// File: rtl/tta_move_core_chk.sv
`timescale 1ns/1ps
// Module: tta_move_core_chk
// Property checker bound into tta_move_core. Relates the incoming word's
// guard codes to each slot's effect, and checks hold and load behaviour of
// the result, guard and long-immediate registers.
module tta_move_core_chk #(
    parameter int NUM_SLOTS  = 4,
    parameter int DATA_W     = 32,
    parameter int NUM_GUARDS = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      instr_valid,
    input logic [NUM_SLOTS*16-1:0]   instr_word,
    input logic                      instr_limm_en,
    input logic [DATA_W-1:0]         instr_limm,
    input logic [NUM_SLOTS-1:0]      xfer_en,
    input logic [NUM_GUARDS-1:0]     guard_state,
    input logic [DATA_W-1:0]         alu_r,
    input logic [DATA_W-1:0]         cmp_r,
    input logic [DATA_W-1:0]         limm_q
);
    logic [NUM_GUARDS:0] gvec;
    assign gvec = {guard_state, 1'b1};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_s
        logic [1:0] code;
        assign code = instr_word[s*16+13 +: 2];

        assert_guard_false_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_valid && !gvec[code]) |-> !xfer_en[s]);
        assert_code0_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_valid && code == 2'd0) |-> xfer_en[s]);
        assert_no_valid_no_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !instr_valid |-> !xfer_en[s]);
    end

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(guard_state) && $stable(alu_r) && $stable(cmp_r)));

    assert_limm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_limm_en) |=> limm_q == $past(instr_limm));

    assert_limm_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && instr_limm_en) |=> $stable(limm_q));

    assert_cmp_binary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_r[DATA_W-1:1] == '0);

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (guard_state == '0 && alu_r == '0 && cmp_r == '0 && limm_q == '0));
endmodule

bind tta_move_core tta_move_core_chk #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .NUM_GUARDS(NUM_GUARDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_limm_en(instr_limm_en), .instr_limm(instr_limm), .xfer_en(xfer_en),
    .guard_state(guard_state), .alu_r(alu_r), .cmp_r(cmp_r), .limm_q(limm_q)
);

// File: tb/test_tta_move_core.sv
`timescale 1ns/1ps
// Bench: random and directed move words against a bench-side model.
module test_tta_move_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [63:0] instr_word = '0;
    logic        instr_limm_en = 1'b0;
    logic [31:0] instr_limm = '0;
    logic [3:0]  insp_sel = '0;
    logic [31:0] insp_data;
    logic [2:0]  guard_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tta_move_core i_tta_move_core (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_limm_en(instr_limm_en), .instr_limm(instr_limm),
        .insp_sel(insp_sel), .insp_data(insp_data), .guard_state(guard_state)
    );

    // Bench model state.
    logic [31:0] m_rf [16];
    logic [2:0]  m_g;
    logic [31:0] m_o1a, m_ra, m_o1c, m_rc, m_limm;

    localparam logic [15:0] NOP = {1'b0, 2'd0, 1'b0, 6'h00, 6'h3F};

    function automatic logic [15:0] mv(input logic [1:0] g, input logic imm,
                                       input logic [5:0] src, input logic [5:0] dst);
        return {1'b0, g, imm, src, dst};
    endfunction

    function automatic logic [31:0] alu_f(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return a << b[4:0];
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_rf[i] = '0;
        m_g = '0; m_o1a = '0; m_ra = '0; m_o1c = '0; m_rc = '0; m_limm = '0;
    endtask

    // Apply one valid word to the model: sample all, then write in slot order.
    task automatic model_step(input logic [63:0] w, input logic le, input logic [31:0] lv);
        logic [31:0] o_rf [16];
        logic [2:0]  o_g;
        logic [31:0] o_o1a, o_ra, o_o1c, o_rc, o_limm, v;
        logic [15:0] sl;
        logic        ok;
        int d;
        for (int i = 0; i < 16; i++) o_rf[i] = m_rf[i];
        o_g = m_g; o_o1a = m_o1a; o_ra = m_ra; o_o1c = m_o1c; o_rc = m_rc; o_limm = m_limm;
        for (int s = 0; s < 4; s++) begin
            sl = w[s*16 +: 16];
            ok = (sl[14:13] == 2'd0) ? 1'b1 : o_g[sl[14:13]-1];
            if (sl[12])              v = {{26{sl[11]}}, sl[11:6]};
            else if (sl[11:6] < 16)  v = o_rf[sl[9:6]];
            else if (sl[11:6] == 6'h10) v = o_ra;
            else if (sl[11:6] == 6'h11) v = o_rc;
            else if (sl[11:6] == 6'h12) v = o_limm;
            else                     v = '0;
            d = int'(sl[5:0]);
            if (ok) begin
                if (d < 16)                 m_rf[d] = v;
                else if (d == 'h10)         m_o1a = v;
                else if (d >= 'h18 && d <= 'h1D) m_ra = alu_f(d - 'h18, o_o1a, v);
                else if (d == 'h20)         m_o1c = v;
                else if (d == 'h21)         m_rc = {31'd0, o_o1c == v};
                else if (d == 'h22)         m_rc = {31'd0, $signed(o_o1c) < $signed(v)};
                else if (d >= 'h29 && d <= 'h2B) m_g[d - 'h29] = v[0];
            end
        end
        if (le) m_limm = lv;
    endtask

    // Drive one valid word across exactly one rising edge, then update model.
    task automatic issue(input logic [63:0] w, input logic le = 1'b0, input logic [31:0] lv = '0);
        @(negedge clk);
        instr_word = w; instr_valid = 1'b1; instr_limm_en = le; instr_limm = lv;
        @(posedge clk);
        #1;
        instr_valid = 1'b0; instr_limm_en = 1'b0;
        model_step(w, le, lv);
    endtask

    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        insp_sel = 4'(idx);
        #0.4;
        val = insp_data;
    endtask

    // Compare every register and the guards with the model (R11 inspection).
    task automatic check_state(input string req);
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            check_val(req, $sformatf("reg %0d", i), v, m_rf[i]);
        end
        check_val(req, "guards", {29'd0, guard_state}, {29'd0, m_g});
    endtask

    function automatic logic [5:0] rnd_src();
        case ($urandom % 5)
            0, 1:    return 6'($urandom % 16);
            2:       return 6'h10 + 6'($urandom % 3);
            3:       return 6'($urandom % 16);
            default: return 6'($urandom);
        endcase
    endfunction

    function automatic logic [5:0] rnd_dst();
        case ($urandom % 8)
            0, 1, 2: return 6'($urandom % 16);
            3:       return 6'h10;
            4:       return 6'h18 + 6'($urandom % 8);
            5:       return 6'h20 + 6'($urandom % 3);
            6:       return 6'h29 + 6'($urandom % 3);
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_state("R9");

        // R2: short immediates, sign-extended.
        issue({NOP, NOP, mv(0, 1, 6'h1F, 6'd2), mv(0, 1, 6'h3B, 6'd1)});
        read_reg(1, v); check_val("R2", "r1 = -5", v, 32'hFFFF_FFFB);
        read_reg(2, v); check_val("R2", "r2 = 31", v, 32'h0000_001F);

        // R4: operand then sub trigger, result moved out next word.
        issue({NOP, NOP, NOP, mv(0, 0, 6'd2, 6'h10)});
        issue({NOP, NOP, NOP, mv(0, 0, 6'd1, 6'h19)});
        issue({NOP, NOP, NOP, mv(0, 0, 6'h10, 6'd4)});
        read_reg(4, v); check_val("R4", "31 - (-5)", v, 32'h0000_0024);

        // R3: long immediate read in same word sees old, next word sees new.
        issue({NOP, NOP, NOP, mv(0, 0, 6'h12, 6'd3)}, 1'b1, 32'hCAFE_F00D);
        read_reg(3, v); check_val("R3", "same-word limm", v, 32'h0);
        issue({NOP, NOP, NOP, mv(0, 0, 6'h12, 6'd3)});
        read_reg(3, v); check_val("R3", "next-word limm", v, 32'hCAFE_F00D);

        // R5/R6/R1: signed compare into g1, then guarded moves.
        issue({NOP, NOP, NOP, mv(0, 0, 6'd1, 6'h20)});
        issue({NOP, NOP, NOP, mv(0, 0, 6'd2, 6'h22)});
        issue({NOP, NOP, NOP, mv(0, 0, 6'h11, 6'h29)});
        check_val("R6", "g1 from -5<31", {29'd0, guard_state}, 32'd1);
        issue({NOP, NOP, mv(2, 1, 6'd9, 6'd8), mv(1, 1, 6'd7, 6'd7)});
        read_reg(7, v); check_val("R1", "g1 true move", v, 32'd7);
        read_reg(8, v); check_val("R1", "g2 false dropped", v, 32'd0);

        // R8: three slots hit r5, slot 3 wins.
        issue({mv(0, 1, 6'd3, 6'd5), mv(0, 1, 6'd2, 6'd5), NOP, mv(0, 1, 6'd1, 6'd5)});
        read_reg(5, v); check_val("R8", "highest slot wins", v, 32'd3);

        // R7: slot 1 reads r6 that slot 0 writes in the same word.
        issue({NOP, NOP, mv(0, 0, 6'd6, 6'd9), mv(0, 1, 6'd10, 6'd6)});
        read_reg(9, v); check_val("R7", "read before write", v, 32'd0);
        read_reg(6, v); check_val("R7", "write landed", v, 32'd10);

        // R10: unmapped source reads zero, unmapped destination dropped.
        issue({NOP, NOP, mv(0, 1, 6'd5, 6'h3E), mv(0, 0, 6'h3F, 6'd1)});
        read_reg(1, v); check_val("R10", "unmapped src", v, 32'd0);
        check_state("R10");

        // R1: word present with valid low changes nothing.
        @(negedge clk);
        instr_word = {mv(0, 1, 6'd1, 6'd0), mv(0, 1, 6'd1, 6'h29),
                      mv(0, 1, 6'd2, 6'd11), mv(0, 1, 6'd3, 6'h18)};
        instr_limm_en = 1'b1; instr_limm = 32'h1111_2222;
        @(posedge clk); #1;
        instr_limm_en = 1'b0;
        check_state("R1");
        issue({NOP, NOP, NOP, mv(0, 0, 6'h12, 6'd12)});
        read_reg(12, v); check_val("R3", "limm ignored when invalid", v, 32'hCAFE_F00D);

        // Random words (R4, R5, R6, R7, R8 via model).
        for (int n = 0; n < 600; n++) begin
            logic [63:0] w;
            for (int s = 0; s < 4; s++) begin
                logic [1:0] g;
                g = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
                w[s*16 +: 16] = mv(g, ($urandom % 4) == 0, rnd_src(), rnd_dst());
            end
            issue(w, ($urandom % 8) == 0, $urandom);
            if (n % 4 == 0) check_state("R4");
            else check_val("R6", "guards", {29'd0, guard_state}, {29'd0, m_g});
        end
        check_state("R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule